// File: doc/BRIEF.md
# Modem Control and Interrupt Pin Slice

This block holds the modem-facing state of one channel of a 16550-class serial port. A host processor reaches it through an 8-bit register port. The port has an active-low chip select, a 3-bit register address, and active-low read and write strobes. From the stored modem control value the block drives three pins: the active-low data-terminal-ready output, the user output, and the channel interrupt pin with its output enable. The interrupt output enable stands in for a tri-state driver.

The block also synchronizes the three active-low modem inputs (clear-to-send, data-set-ready and carrier-detect). It presents their levels and change flags in a modem status register. When automatic clear-to-send flow control is switched on, it withholds permission to start new transmit characters while clear-to-send is inactive. A dual-channel part uses two instances, one per chip select. Each instance keeps its own register set. Strobes and data are sampled on the block clock, so the host port is treated as synchronous to it.

Top module: `mdm_ctl_slice`

## Requirements
- R1: After reset `dtr_n`=1, `op_n`=1, `int_oe`=0, `int_o`=0, `tx_permit`=1, `rdata_oe`=0. A read of the modem control, modem status and feature registers then returns 0x00.
- R2: Modem control bit 0 set to 1 drives `dtr_n` low. Set to 0, it drives `dtr_n` high.
- R3: Modem control bit 3 set to 1 gives `int_oe`=1, `op_n`=0 and `int_o` following `irq_req`. Set to 0, it gives `int_oe`=0, `op_n`=1 and `int_o`=0.
- R4: Modem status (address 6) bits 4, 5 and 7 read as the inverted synchronized levels of `cts_n`, `dsr_n` and `cd_n`. Bits 2 and 6 read 0.
- R5: Modem status bits 0, 1 and 3 are set when the synchronized `cts_n`, `dsr_n` or `cd_n` changes level, respectively. A read of address 6 clears them.
- R6: With feature register (address 7) bit 7 at 0, `tx_permit` is 1. With it at 1, `tx_permit` is 0 while synchronized `cts_n` is high and 1 while it is low.
- R7: A falling edge of `rd_n` with `cs_n` low loads `rdata` from the addressed register. Address 4 returns the modem control bits 4:0 with bits 7:5 as 0. Address 6 returns modem status, address 7 returns all 8 feature bits, and every other address returns 0x00.
- R8: A rising edge of `wr_n` with `cs_n` low writes `wdata` to the addressed register (address 4 or 7). A write with `cs_n` high, or to any other address, changes no register.
- R9: `rdata_oe` is 1 only while `cs_n` and `rd_n` were both low at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Channel select, active low |
| addr | input | 3 | Register address |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data from host |
| rdata | output | 8 | Read data to host |
| rdata_oe | output | 1 | Read data bus drive enable |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| cd_n | input | 1 | Carrier-detect, active low, asynchronous |
| irq_req | input | 1 | Channel interrupt request from the other channel logic |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| op_n | output | 1 | User output, driven opposite to the interrupt enable |
| int_o | output | 1 | Interrupt level when enabled |
| int_oe | output | 1 | Interrupt pin drive enable (0 = high impedance) |
| tx_permit | output | 1 | Transmitter may start a new character |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, a 3-bit address and two synchronizer stages. At that size it can cover the whole problem. It writes all 32 modem control values, all eight modem-input combinations with their change flags, every register address on read, and both flow-control settings against both clear-to-send levels. Expected pin and register values are derived from the written value bit by bit.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int MCR_W   = 5;
  localparam int N_MODEM = 3;

  localparam logic [ADDR_W-1:0] A_MCTL = 3'd4;
  localparam logic [ADDR_W-1:0] A_MSTS = 3'd6;
  localparam logic [ADDR_W-1:0] A_FEAT = 3'd7;

  localparam int B_DTR    = 0;
  localparam int B_IRQEN  = 3;
  localparam int B_AUTOCT = 7;

  // modem input index into synchronized vector
  localparam int M_CTS = 0;
  localparam int M_DSR = 1;
  localparam int M_CD  = 2;

  typedef struct packed {
    logic              cs_n;
    logic              rd_n;
    logic              wr_n;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } host_smp_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= {WIDTH{RST_VAL}};
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= {WIDTH{RST_VAL}};
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_host_if.sv
module mdm_host_if
  import mdm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_fire,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rdata_oe
);
  localparam host_smp_t IDLE = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1,
                                 addr: '0, data: '0};

  host_smp_t s1, s2;
  logic      oe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= IDLE;
      s2   <= IDLE;
      oe_q <= 1'b0;
    end else begin
      s1   <= '{cs_n: cs_n, rd_n: rd_n, wr_n: wr_n, addr: addr, data: wdata};
      s2   <= s1;
      oe_q <= ~cs_n & ~rd_n;
    end
  end

  // write commits at the trailing (rising) strobe edge using the values
  // held while the strobe was still low
  assign wr_fire  = ~s2.wr_n & s1.wr_n & ~s2.cs_n;
  assign wr_addr  = s2.addr;
  assign wr_data  = s2.data;
  // read captures at the leading (falling) strobe edge
  assign rd_fire  = ~s1.rd_n & s2.rd_n & ~s1.cs_n;
  assign rd_addr  = s1.addr;
  assign rdata_oe = oe_q;

  a_r9_oe_needs_strobe: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> (~s1.rd_n & ~s1.cs_n));
  a_r8_write_needs_select: assert property (@(posedge clk) disable iff (rst)
    wr_fire |-> $past(~cs_n));
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [N_MODEM-1:0] lvl_n,
  input  logic               rd_clr,
  output logic [DATA_W-1:0]  msts
);
  logic [N_MODEM-1:0] prev_n;
  logic [N_MODEM-1:0] delta;
  logic [N_MODEM-1:0] change;

  assign change = lvl_n ^ prev_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n <= '1;
      delta  <= '0;
    end else begin
      prev_n <= lvl_n;
      for (int i = 0; i < N_MODEM; i++) begin
        if (change[i])   delta[i] <= 1'b1;
        else if (rd_clr) delta[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    msts    = '0;
    msts[0] = delta[M_CTS];
    msts[1] = delta[M_DSR];
    msts[3] = delta[M_CD];
    msts[4] = ~lvl_n[M_CTS];
    msts[5] = ~lvl_n[M_DSR];
    msts[7] = ~lvl_n[M_CD];
  end

  a_r5_delta_from_change: assert property (@(posedge clk) disable iff (rst)
    $rose(delta[M_CTS]) |-> $past(change[M_CTS]));
  a_r5_clear_on_read: assert property (@(posedge clk) disable iff (rst)
    ($past(rd_clr) && !$past(change[M_DSR])) |-> !delta[M_DSR]);
endmodule

// File: rtl/mdm_ctl_slice.sv
module mdm_ctl_slice
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              cd_n,
  input  logic              irq_req,
  output logic              dtr_n,
  output logic              op_n,
  output logic              int_o,
  output logic              int_oe,
  output logic              tx_permit
);
  logic              wr_fire, rd_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data;
  logic [N_MODEM-1:0] lvl_n;
  logic [DATA_W-1:0] msts;
  logic [MCR_W-1:0]  mctl;
  logic [DATA_W-1:0] feat;
  logic              msts_rd;

  mdm_host_if u_host (
    .clk, .rst, .cs_n, .addr, .rd_n, .wr_n, .wdata,
    .wr_fire, .wr_addr, .wr_data, .rd_fire, .rd_addr, .rdata_oe
  );

  mdm_sync #(.WIDTH(N_MODEM), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk, .rst, .d({cd_n, dsr_n, cts_n}), .q(lvl_n)
  );

  assign msts_rd = rd_fire && (rd_addr == A_MSTS);

  mdm_status u_sts (
    .clk, .rst, .lvl_n, .rd_clr(msts_rd), .msts
  );

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      mctl <= '0;
      feat <= '0;
    end else if (wr_fire) begin
      if (wr_addr == A_MCTL) mctl <= wr_data[MCR_W-1:0];
      if (wr_addr == A_FEAT) feat <= wr_data;
    end
  end

  // read capture
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_fire) begin
      unique case (rd_addr)
        A_MCTL:  rdata <= DATA_W'(mctl);
        A_MSTS:  rdata <= msts;
        A_FEAT:  rdata <= feat;
        default: rdata <= '0;
      endcase
    end
  end

  // pin drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      dtr_n     <= 1'b1;
      op_n      <= 1'b1;
      int_oe    <= 1'b0;
      int_o     <= 1'b0;
      tx_permit <= 1'b1;
    end else begin
      dtr_n     <= ~mctl[B_DTR];
      op_n      <= ~mctl[B_IRQEN];
      int_oe    <= mctl[B_IRQEN];
      int_o     <= mctl[B_IRQEN] & irq_req;
      tx_permit <= ~(feat[B_AUTOCT] & lvl_n[M_CTS]);
    end
  end

  a_r3_hiz_quiet: assert property (@(posedge clk) disable iff (rst)
    !int_oe |-> !int_o);
  a_r3_op_opposite: assert property (@(posedge clk) disable iff (rst)
    op_n != int_oe);
  a_r6_no_flow_permits: assert property (@(posedge clk) disable iff (rst)
    !feat[B_AUTOCT] |=> tx_permit);
  a_r8_reg_change_needs_write: assert property (@(posedge clk) disable iff (rst)
    !$stable(mctl) |-> $past(wr_fire));
endmodule

// File: tb/mdm_ctl_slice_tb.sv
module mdm_ctl_slice_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdata_oe;
  logic       cts_n = 1'b1, dsr_n = 1'b1, cd_n = 1'b1, irq_req = 1'b0;
  logic       dtr_n, op_n, int_o, int_oe, tx_permit;

  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  mdm_ctl_slice u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d, input logic sel_n);
    @(negedge clk);
    cs_n = sel_n; addr = a; wdata = d; wr_n = 1'b0;
    idle(2);
    wr_n = 1'b1;
    idle(1);
    cs_n = 1'b1;
    idle(3);
  endtask

  task automatic host_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = a; rd_n = 1'b0;
    idle(4);
    d = rdata;
    chk("R9 oe during read", {7'd0, rdata_oe}, 8'h01);
    rd_n = 1'b1; cs_n = 1'b1;
    idle(3);
    chk("R9 oe after read", {7'd0, rdata_oe}, 8'h00);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, exp_sts;
    logic [2:0] last_lvl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 dtr_n", {7'd0, dtr_n}, 8'h01);
    chk("R1 op_n", {7'd0, op_n}, 8'h01);
    chk("R1 int_oe", {7'd0, int_oe}, 8'h00);
    chk("R1 int_o", {7'd0, int_o}, 8'h00);
    chk("R1 tx_permit", {7'd0, tx_permit}, 8'h01);
    chk("R1 rdata_oe", {7'd0, rdata_oe}, 8'h00);
    host_rd(3'd4, d); chk("R1 mctl", d, 8'h00);
    host_rd(3'd6, d); chk("R1 msts", d, 8'h00);
    host_rd(3'd7, d); chk("R1 feat", d, 8'h00);

    // R2 R3 R7 sweep of all modem control values and interrupt levels
    for (int v = 0; v < 32; v++) begin
      host_wr(3'd4, {3'b101, v[4:0]}, 1'b0);
      for (int q = 0; q < 2; q++) begin
        irq_req = q[0];
        idle(2);
        chk("R2 dtr_n", {7'd0, dtr_n}, {7'd0, ~v[0]});
        chk("R3 int_oe", {7'd0, int_oe}, {7'd0, v[3]});
        chk("R3 op_n", {7'd0, op_n}, {7'd0, ~v[3]});
        chk("R3 int_o", {7'd0, int_o}, {7'd0, v[3] & q[0]});
      end
      host_rd(3'd4, d);
      chk("R7 mctl readback", d, {3'b000, v[4:0]});
    end

    // R8 deselected write and write to other address leave registers
    host_wr(3'd4, 8'h09, 1'b0);
    host_wr(3'd4, 8'h00, 1'b1);
    idle(2);
    chk("R8 cs high dtr", {7'd0, dtr_n}, 8'h00);
    host_rd(3'd4, d); chk("R8 cs high mctl", d, 8'h09);
    host_wr(3'd7, 8'h5A, 1'b0);
    host_wr(3'd7, 8'hFF, 1'b1);
    host_wr(3'd3, 8'hFF, 1'b0);
    host_rd(3'd7, d); chk("R8 feat kept", d, 8'h5A);
    host_rd(3'd4, d); chk("R8 other addr", d, 8'h09);

    // R7 unmapped addresses read zero
    for (int a = 0; a < 8; a++) begin
      if (a != 4 && a != 6 && a != 7) begin
        host_rd(a[2:0], d); chk("R7 unmapped", d, 8'h00);
      end
    end

    // R4 R5 modem input sweep
    last_lvl = 3'b111;
    for (int c = 0; c < 8; c++) begin
      {cd_n, dsr_n, cts_n} = c[2:0] ^ 3'b101;
      idle(6);
      exp_sts = 8'h00;
      exp_sts[4] = ~cts_n; exp_sts[5] = ~dsr_n; exp_sts[7] = ~cd_n;
      exp_sts[0] = cts_n ^ last_lvl[0];
      exp_sts[1] = dsr_n ^ last_lvl[1];
      exp_sts[3] = cd_n ^ last_lvl[2];
      host_rd(3'd6, d); chk("R4 R5 msts", d, exp_sts);
      exp_sts[0] = 1'b0; exp_sts[1] = 1'b0; exp_sts[3] = 1'b0;
      host_rd(3'd6, d); chk("R5 cleared", d, exp_sts);
      last_lvl = {cd_n, dsr_n, cts_n};
    end

    // R6 flow control against cts level
    for (int f = 0; f < 2; f++) begin
      host_wr(3'd7, {f[0], 7'h00}, 1'b0);
      for (int c = 0; c < 2; c++) begin
        cts_n = c[0];
        idle(6);
        chk("R6 tx_permit", {7'd0, tx_permit}, {7'd0, ~(f[0] & c[0])});
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule